// File: doc/BRIEF.md
# Saturating Accumulator Update Stage

This block keeps a 40-bit multiply-accumulate accumulator and folds one product into it per enabled cycle. An operation select loads the product, adds it, or subtracts it. A mode code chooses how the result is clamped. Signed modes clamp to the two's-complement range of the accumulator. Unsigned modes clamp to the range from zero up to all ones. The product arrives already extended to accumulator width by the multiplier in front of the block.

The operands are widened by two guard bits before the arithmetic, so any overflow of the 40-bit range is visible before the clamp decides. The clamped value is stored on a clock enable and drives the accumulator output. In the same cycle the stored value appears, two registered flags report whether clamping changed it, or whether the request was refused because the operation or mode code was not legal.

Top module: `sat_acc_update`

## Requirements
- R1: A synchronous reset `rst` clears the accumulator and both flags on the next clock edge, whatever the other inputs are.
- R2: With `en` low, the accumulator keeps its value, and both flags read 0 after the next edge.
- R3: The operation select encodes 0 = load the product, 1 = accumulator plus product, 2 = accumulator minus product. The code 3 is illegal.
- R4: Mode codes 0 to 4 select signed clamping, 5 to 7 select unsigned clamping, and 8 to 15 are illegal.
- R5: In a signed mode, an exact result above 0x7F_FFFF_FFFF is stored as 0x7F_FFFF_FFFF. A result equal to that value is stored unchanged and is not flagged.
- R6: In a signed mode, an exact result below -2^39 is stored as 0x80_0000_0000. A result equal to -2^39 is stored unchanged and is not flagged.
- R7: In an unsigned mode, an exact result above 0xFF_FFFF_FFFF is stored as 0xFF_FFFF_FFFF.
- R8: In an unsigned mode, an exact result below zero is stored as zero.
- R9: `sat_flag` is registered together with the accumulator. It is 1 in exactly those cycles whose stored value differs from the exact result. When it is 1, the accumulator holds one of the four clamp limits.
- R10: An enabled request with an illegal operation or mode code leaves the accumulator unchanged. It raises `illegal_flag` for that cycle and keeps `sat_flag` at 0.
- R11: In signed modes, the accumulator and the product are sign-extended. In unsigned modes, both are zero-extended. For example, 0xFF_FFFF_FFFF plus 1 gives 0 when signed and clamps to all ones when unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable |
| op_sel | input | 2 | Operation: 0 load, 1 add, 2 subtract |
| mode | input | 4 | Clamp mode code |
| prod | input | 40 | Extended product |
| acc_q | output | 40 | Stored accumulator |
| sat_flag | output | 1 | Last update was clamped |
| illegal_flag | output | 1 | Last request was refused |

## Verification
The same enabled cycle can both update the stored value and decide the clamp flag. The arithmetic uses the value the accumulator held before that edge. The table therefore chains its rows: each row starts from the value the previous row left, and expects both the new value and the flag in the very next cycle. Rows sit exactly on a limit and one step past it, so a flag that fires on equality, or a clamp that takes the wrong side, stands out. Idle and refused rows that follow a clamped row confirm that the flag drops in the next cycle while the value holds.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [1:0] {
      ACC_OP_LOAD = 2'd0,
      ACC_OP_ADD  = 2'd1,
      ACC_OP_SUB  = 2'd2,
      ACC_OP_RSVD = 2'd3
   } acc_op_e;

   typedef enum logic [1:0] {
      CLAMP_SIGNED   = 2'd0,
      CLAMP_UNSIGNED = 2'd1,
      CLAMP_BAD      = 2'd2
   } clamp_kind_e;

endpackage

// File: rtl/sacc_mode_dec.sv
module sacc_mode_dec
   import sacc_pkg::*;
#(
   parameter int N_SIGNED   = 5,
   parameter int N_UNSIGNED = 3
) (
   input  logic [MODE_W-1:0] mode_i,
   output clamp_kind_e        kind_o
);
   localparam int FIRST_UNS = N_SIGNED;
   localparam int LAST_CODE = N_SIGNED + N_UNSIGNED - 1;

   generate
      if (N_SIGNED < 1 || N_UNSIGNED < 1 || LAST_CODE >= (1 << MODE_W)) begin : g_bad_cfg
         $error("sacc_mode_dec: mode code space too small");
      end
   endgenerate

   always_comb begin
      if (int'(mode_i) < FIRST_UNS)
         kind_o = CLAMP_SIGNED;
      else if (int'(mode_i) <= LAST_CODE)
         kind_o = CLAMP_UNSIGNED;
      else
         kind_o = CLAMP_BAD;
   end
endmodule

// File: rtl/sacc_addsub.sv
module sacc_addsub
   import sacc_pkg::*;
#(
   parameter int ACC_W = 40,
   parameter int GUARD = 2
) (
   input  logic [ACC_W-1:0]               acc_i,
   input  logic [ACC_W-1:0]               prod_i,
   input  logic [1:0]                     op_i,
   input  logic                           zext_i,
   output logic signed [ACC_W+GUARD-1:0]  sum_o,
   output logic                           op_bad_o
);
   localparam int EXT_W = ACC_W + GUARD;

   generate
      if (GUARD < 2) begin : g_bad_guard
         $error("sacc_addsub: at least two guard bits needed");
      end
   endgenerate

   logic signed [EXT_W-1:0] acc_x, prod_x;

   always_comb begin
      if (zext_i) begin
         acc_x  = {{GUARD{1'b0}}, acc_i};
         prod_x = {{GUARD{1'b0}}, prod_i};
      end else begin
         acc_x  = {{GUARD{acc_i[ACC_W-1]}}, acc_i};
         prod_x = {{GUARD{prod_i[ACC_W-1]}}, prod_i};
      end
   end

   always_comb begin
      op_bad_o = 1'b0;
      unique case (acc_op_e'(op_i))
         ACC_OP_LOAD: sum_o = prod_x;
         ACC_OP_ADD:  sum_o = acc_x + prod_x;
         ACC_OP_SUB:  sum_o = acc_x - prod_x;
         default: begin
            sum_o    = acc_x;
            op_bad_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/sacc_clamp.sv
module sacc_clamp #(
   parameter int ACC_W = 40,
   parameter int GUARD = 2
) (
   input  logic signed [ACC_W+GUARD-1:0] sum_i,
   input  logic                          uns_i,
   output logic [ACC_W-1:0]              res_o,
   output logic                          clamped_o
);
   localparam int EXT_W = ACC_W + GUARD;
   localparam logic signed [EXT_W-1:0] S_MAX = {{(GUARD+1){1'b0}}, {(ACC_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] S_MIN = {{(GUARD+1){1'b1}}, {(ACC_W-1){1'b0}}};
   localparam logic signed [EXT_W-1:0] U_MAX = {{GUARD{1'b0}}, {ACC_W{1'b1}}};
   localparam logic signed [EXT_W-1:0] U_MIN = '0;

   logic signed [EXT_W-1:0] hi_lim, lo_lim;

   assign hi_lim = uns_i ? U_MAX : S_MAX;
   assign lo_lim = uns_i ? U_MIN : S_MIN;

   always_comb begin
      clamped_o = 1'b1;
      if (sum_i > hi_lim)
         res_o = hi_lim[ACC_W-1:0];
      else if (sum_i < lo_lim)
         res_o = lo_lim[ACC_W-1:0];
      else begin
         res_o     = sum_i[ACC_W-1:0];
         clamped_o = 1'b0;
      end
   end
endmodule

// File: rtl/sat_acc_update.sv
module sat_acc_update
   import sacc_pkg::*;
#(
   parameter int ACC_W      = 40,
   parameter int GUARD      = 2,
   parameter int N_SIGNED   = 5,
   parameter int N_UNSIGNED = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [1:0]        op_sel,
   input  logic [3:0]        mode,
   input  logic [ACC_W-1:0]  prod,
   output logic [ACC_W-1:0]  acc_q,
   output logic              sat_flag,
   output logic              illegal_flag
);
   localparam int EXT_W = ACC_W + GUARD;
   localparam logic [ACC_W-1:0] LIM_SMAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] LIM_SMIN = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic [ACC_W-1:0] LIM_UMAX = {ACC_W{1'b1}};

   generate
      if (ACC_W < 8 || MODE_W != 4) begin : g_bad_width
         $error("sat_acc_update: unsupported width");
      end
   endgenerate

   clamp_kind_e              kind;
   logic                     op_bad, refuse, clamped;
   logic signed [EXT_W-1:0]  sum;
   logic [ACC_W-1:0]         res;

   sacc_mode_dec #(.N_SIGNED(N_SIGNED), .N_UNSIGNED(N_UNSIGNED)) u_dec (
      .mode_i (mode),
      .kind_o (kind)
   );

   sacc_addsub #(.ACC_W(ACC_W), .GUARD(GUARD)) u_arith (
      .acc_i    (acc_q),
      .prod_i   (prod),
      .op_i     (op_sel),
      .zext_i   (kind == CLAMP_UNSIGNED),
      .sum_o    (sum),
      .op_bad_o (op_bad)
   );

   sacc_clamp #(.ACC_W(ACC_W), .GUARD(GUARD)) u_clamp (
      .sum_i     (sum),
      .uns_i     (kind == CLAMP_UNSIGNED),
      .res_o     (res),
      .clamped_o (clamped)
   );

   assign refuse = op_bad || (kind == CLAMP_BAD);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q        <= '0;
         sat_flag     <= 1'b0;
         illegal_flag <= 1'b0;
      end else begin
         sat_flag     <= 1'b0;
         illegal_flag <= 1'b0;
         if (en) begin
            if (refuse) begin
               illegal_flag <= 1'b1;
            end else begin
               acc_q    <= res;
               sat_flag <= clamped;
            end
         end
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (acc_q == '0 && !sat_flag && !illegal_flag)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(acc_q) && !sat_flag && !illegal_flag)); // R2
   AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (en && refuse) |=> ($stable(acc_q) && illegal_flag && !sat_flag)); // R10
   AST_SAT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
      sat_flag |-> (acc_q == LIM_SMAX || acc_q == LIM_SMIN ||
                    acc_q == LIM_UMAX || acc_q == '0)); // R9
   AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst)
      !(sat_flag && illegal_flag)); // R9
endmodule

// File: tb/sat_acc_update_tb.sv
`timescale 1ns/100ps
module sat_acc_update_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic [1:0]  op_sel = 2'd0;
   logic [3:0]  mode = 4'd0;
   logic [39:0] prod = '0;
   logic [39:0] acc_q;
   logic        sat_flag, illegal_flag;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sat_acc_update dut_i (
      .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .mode(mode), .prod(prod),
      .acc_q(acc_q), .sat_flag(sat_flag), .illegal_flag(illegal_flag)
   );

   // row: {req[3:0], en, op[1:0], mode[3:0], prod[39:0], acc[39:0], sat, ill}
   localparam int NV = 27;
   localparam logic [92:0] VEC [NV] = '{
      {4'd3,  1'b1, 2'd0, 4'd0, 40'h00_0000_0005, 40'h00_0000_0005, 1'b0, 1'b0}, // R3 load
      {4'd3,  1'b1, 2'd1, 4'd0, 40'h00_0000_0003, 40'h00_0000_0008, 1'b0, 1'b0}, // R3 add
      {4'd3,  1'b1, 2'd2, 4'd0, 40'h00_0000_0010, 40'hFF_FFFF_FFF8, 1'b0, 1'b0}, // R3 sub
      {4'd5,  1'b1, 2'd0, 4'd0, 40'h7F_FFFF_FFF0, 40'h7F_FFFF_FFF0, 1'b0, 1'b0}, // R5
      {4'd5,  1'b1, 2'd1, 4'd1, 40'h00_0000_000F, 40'h7F_FFFF_FFFF, 1'b0, 1'b0}, // R5 equal
      {4'd5,  1'b1, 2'd1, 4'd2, 40'h00_0000_0001, 40'h7F_FFFF_FFFF, 1'b1, 1'b0}, // R5 over
      {4'd6,  1'b1, 2'd0, 4'd3, 40'h80_0000_0001, 40'h80_0000_0001, 1'b0, 1'b0}, // R6
      {4'd6,  1'b1, 2'd2, 4'd4, 40'h00_0000_0001, 40'h80_0000_0000, 1'b0, 1'b0}, // R6 equal
      {4'd6,  1'b1, 2'd2, 4'd0, 40'h00_0000_0001, 40'h80_0000_0000, 1'b1, 1'b0}, // R6 under
      {4'd6,  1'b1, 2'd1, 4'd0, 40'hFF_FFFF_FFFF, 40'h80_0000_0000, 1'b1, 1'b0}, // R6 add -1
      {4'd11, 1'b1, 2'd0, 4'd5, 40'hFF_FFFF_FFFE, 40'hFF_FFFF_FFFE, 1'b0, 1'b0}, // R11
      {4'd7,  1'b1, 2'd1, 4'd6, 40'h00_0000_0001, 40'hFF_FFFF_FFFF, 1'b0, 1'b0}, // R7 equal
      {4'd7,  1'b1, 2'd1, 4'd7, 40'h00_0000_0001, 40'hFF_FFFF_FFFF, 1'b1, 1'b0}, // R7 over
      {4'd8,  1'b1, 2'd0, 4'd5, 40'h00_0000_0004, 40'h00_0000_0004, 1'b0, 1'b0}, // R8
      {4'd8,  1'b1, 2'd2, 4'd6, 40'h00_0000_0005, 40'h00_0000_0000, 1'b1, 1'b0}, // R8 under
      {4'd2,  1'b0, 2'd1, 4'd0, 40'h00_0000_0007, 40'h00_0000_0000, 1'b0, 1'b0}, // R2 idle
      {4'd8,  1'b1, 2'd2, 4'd5, 40'h00_0000_0000, 40'h00_0000_0000, 1'b0, 1'b0}, // R8 zero
      {4'd3,  1'b1, 2'd0, 4'd0, 40'h12_3456_789A, 40'h12_3456_789A, 1'b0, 1'b0}, // R3
      {4'd4,  1'b1, 2'd1, 4'd8, 40'h00_0000_0001, 40'h12_3456_789A, 1'b0, 1'b1}, // R4 bad mode
      {4'd10, 1'b1, 2'd3, 4'd0, 40'h00_0000_0001, 40'h12_3456_789A, 1'b0, 1'b1}, // R10 bad op
      {4'd10, 1'b1, 2'd2, 4'd15,40'h00_0000_0001, 40'h12_3456_789A, 1'b0, 1'b1}, // R10
      {4'd2,  1'b0, 2'd3, 4'd9, 40'h00_0000_0001, 40'h12_3456_789A, 1'b0, 1'b0}, // R2
      {4'd11, 1'b1, 2'd0, 4'd0, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 1'b0, 1'b0}, // R11
      {4'd11, 1'b1, 2'd1, 4'd0, 40'h00_0000_0001, 40'h00_0000_0000, 1'b0, 1'b0}, // R11 signed wrap
      {4'd5,  1'b1, 2'd0, 4'd0, 40'h40_0000_0000, 40'h40_0000_0000, 1'b0, 1'b0}, // R5
      {4'd5,  1'b1, 2'd1, 4'd0, 40'h40_0000_0000, 40'h7F_FFFF_FFFF, 1'b1, 1'b0}, // R5 big
      {4'd9,  1'b1, 2'd1, 4'd4, 40'h80_0000_0000, 40'hFF_FFFF_FFFF, 1'b0, 1'b0}  // R9
   };

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic e, input logic [1:0] o, input logic [3:0] m,
                       input logic [39:0] p);
      en = e; op_sel = o; mode = m; prod = p;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1: reset dominates an enabled load
      rst = 1'b1;
      @(negedge clk);
      step(1'b1, 2'd0, 4'd0, 40'h55_5555_5555);
      check("R1 acc", acc_q, 40'h0);
      check("R1 sat", {39'h0, sat_flag}, 40'h0);
      check("R1 ill", {39'h0, illegal_flag}, 40'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [92:0] r;
         string tag;
         r = VEC[i];
         step(r[88], r[87:86], r[85:82], r[81:42]);
         tag = $sformatf("R%0d row%0d", r[92:89], i);
         check({tag, " acc"}, acc_q, r[41:2]);
         check({tag, " sat"}, {39'h0, sat_flag}, {39'h0, r[1]});
         check({tag, " ill"}, {39'h0, illegal_flag}, {39'h0, r[0]});
      end

      // R9: a clamped cycle followed by a legal unclamped one drops the flag
      step(1'b1, 2'd1, 4'd0, 40'h7F_FFFF_FFFF);
      step(1'b1, 2'd1, 4'd0, 40'h7F_FFFF_FFFF);
      check("R9 sat set", {39'h0, sat_flag}, 40'h1);
      step(1'b1, 2'd2, 4'd0, 40'h00_0000_0001);
      check("R9 sat drop", {39'h0, sat_flag}, 40'h0);
      check("R9 acc", acc_q, 40'h7F_FFFF_FFFE);

      // R1: reset mid-run from a nonzero, flagged state
      step(1'b1, 2'd3, 4'd0, 40'h1);
      rst = 1'b1;
      step(1'b1, 2'd1, 4'd0, 40'h1);
      check("R1 mid acc", acc_q, 40'h0);
      check("R1 mid ill", {39'h0, illegal_flag}, 40'h0);
      rst = 1'b0;
      step(1'b0, 2'd0, 4'd0, 40'h0);
      check("R1 stays", acc_q, 40'h0);

      finish_run();
   end
endmodule